// File: doc/BRIEF.md
# PWM Fault Latch with Dead-Time Current Sampling

This block watches four fault inputs of a six-output motor PWM stage. A rising edge on any fault input sets a sticky flag for that channel. Software reads the flags over a small byte-wide register bus and clears each one by writing a one to its acknowledge bit. Any set flag drives an interrupt request.

The block also offers a self-test view of the current-sense hardware. A dead-time interval for a PWM output can end with that output switching on. At that moment a sample bit records the synchronized level of the current-sense input that serves the output's phase leg. Software can then confirm that each sense comparator reacts as expected on every leg. All fault and sense pins pass through a two-stage synchronizer. The PWM drive and dead-time indications come from on-chip logic and are used as they arrive.

Top module: `pwm_fault_monitor`

## Requirements
- R1: After reset, all fault flags, all sample bits and `irq` are 0, and every register reads 0.
- R2: A 0-to-1 transition on `fault_pin[i]` sets flag i. The flag reads 1 no later than two clock cycles after the first rising clock edge that samples the pin high. A pin held high sets the flag only once.
- R3: A set flag stays at 1 after its pin returns low, until it is acknowledged.
- R4: A bus write to address 1 with data bit i = 1 clears flag i on that clock edge. Data bits that are 0 leave their flags unchanged.
- R5: If a new rising edge on pin i and an acknowledge of flag i land on the same clock edge, flag i ends up set.
- R6: A read of address 1 (acknowledge register) always returns 0.
- R7: Sample bit k (k = 0..5) reads at address 2, bit k. It captures synchronized `sense_pin[k/2]` on the clock edge where `dt_active[k]` falls from 1 to 0 while `pwm_drive[k]` is 1. Bits 5 and 4 use sense input 2, bits 3 and 2 use input 1, and bits 1 and 0 use input 0.
- R8: Sample bits hold their value when no capture happens. A dead-time end with `pwm_drive[k]` low does not capture, and writes to address 2 have no effect.
- R9: `irq` is 1 exactly when at least one fault flag is 1.
- R10: Address 0 returns flag i on bit i, with bits 7:4 at 0. Address 2 returns bits 7:6 at 0. Address 3 reads 0. `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe; selects read data |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| fault_pin | input | 4 | Asynchronous fault inputs |
| sense_pin | input | 3 | Asynchronous current-sense inputs |
| pwm_drive | input | 6 | PWM output drive levels |
| dt_active | input | 6 | Per-output dead-time-in-progress indication |
| irq | output | 1 | Interrupt request, OR of the fault flags |

## Verification
The assertions check the flag rules on every cycle: set after a detected edge, clear after an acknowledge without an edge, hold otherwise, and set winning a collision. They also check on every cycle that each sample bit copies its mapped sense line on a capture event and is stable otherwise, that the acknowledge register reads zero, and that an interrupt only rises after an edge. The two-stage synchronizer latency, the full acknowledge-pattern sweep over all flag combinations, the leg-to-sense mapping with opposite levels on the other legs, and the ignored sample writes can only be shown through the bench's scenarios at the ports.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t ADDR_FLAGS  = 2'd0;
  localparam addr_t ADDR_ACK    = 2'd1;
  localparam addr_t ADDR_SAMPLE = 2'd2;

  // Which sense input serves PWM channel ch (legs share one sense line)
  function automatic int sense_of(input int ch, input int npwm, input int nsense);
    return (ch * nsense) / npwm;
  endfunction
endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pfm_fault_bank.sv
module pfm_fault_bank #(
  parameter int NFAULT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFAULT-1:0] pin_s,
  input  logic [NFAULT-1:0] ack_vec,
  output logic [NFAULT-1:0] rise_evt,
  output logic [NFAULT-1:0] flags
);
  logic [NFAULT-1:0] pin_q;

  assign rise_evt = pin_s & ~pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
      flags <= '0;
    end else begin
      pin_q <= pin_s;
      flags <= (flags & ~ack_vec) | rise_evt;
    end
  end
endmodule

// File: rtl/pfm_sense_capture.sv
module pfm_sense_capture #(
  parameter int NPWM   = 6,
  parameter int NSENSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSENSE-1:0] sense_s,
  input  logic [NPWM-1:0]   pwm_drive,
  input  logic [NPWM-1:0]   dt_active,
  output logic [NPWM-1:0]   cap_evt,
  output logic [NPWM-1:0]   samples
);
  logic [NPWM-1:0] dt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dt_q <= '0;
    else        dt_q <= dt_active;
  end

  for (genvar k = 0; k < NPWM; k++) begin : g_ch
    localparam int SEL = pfm_pkg::sense_of(k, NPWM, NSENSE);
    assign cap_evt[k] = dt_q[k] & ~dt_active[k] & pwm_drive[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          samples[k] <= 1'b0;
      else if (cap_evt[k]) samples[k] <= sense_s[SEL];
    end
  end
endmodule

// File: rtl/pwm_fault_monitor.sv
module pwm_fault_monitor
  import pfm_pkg::*;
#(
  parameter int NFAULT      = 4,
  parameter int NPWM        = 6,
  parameter int NSENSE      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NFAULT-1:0] fault_pin,
  input  logic [NSENSE-1:0] sense_pin,
  input  logic [NPWM-1:0]   pwm_drive,
  input  logic [NPWM-1:0]   dt_active,
  output logic              irq
);
  logic [NFAULT-1:0] fault_s, rise_evt, ack_vec, flags;
  logic [NSENSE-1:0] sense_s;
  logic [NPWM-1:0]   cap_evt, samples;

  pfm_sync #(.W(NFAULT), .STAGES(SYNC_STAGES)) u_fault_sync (
    .clk(clk), .rst_n(rst_n), .d(fault_pin), .q(fault_s));

  pfm_sync #(.W(NSENSE), .STAGES(SYNC_STAGES)) u_sense_sync (
    .clk(clk), .rst_n(rst_n), .d(sense_pin), .q(sense_s));

  assign ack_vec = (wr_en && addr == ADDR_ACK) ? wr_data[NFAULT-1:0] : '0;

  pfm_fault_bank #(.NFAULT(NFAULT)) u_bank (
    .clk(clk), .rst_n(rst_n), .pin_s(fault_s), .ack_vec(ack_vec),
    .rise_evt(rise_evt), .flags(flags));

  pfm_sense_capture #(.NPWM(NPWM), .NSENSE(NSENSE)) u_cap (
    .clk(clk), .rst_n(rst_n), .sense_s(sense_s), .pwm_drive(pwm_drive),
    .dt_active(dt_active), .cap_evt(cap_evt), .samples(samples));

  assign irq = |flags;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        ADDR_FLAGS:  rd_data[NFAULT-1:0] = flags;
        ADDR_SAMPLE: rd_data[NPWM-1:0]   = samples;
        default:     rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_fault_monitor_chk.sv
module pwm_fault_monitor_chk
  import pfm_pkg::*;
#(
  parameter int NFAULT = 4,
  parameter int NPWM   = 6,
  parameter int NSENSE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [NFAULT-1:0] rise_evt,
  input logic [NFAULT-1:0] ack_vec,
  input logic [NFAULT-1:0] flags,
  input logic [NSENSE-1:0] sense_s,
  input logic [NPWM-1:0]   cap_evt,
  input logic [NPWM-1:0]   samples
);
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((flags & $past(rise_evt)) == $past(rise_evt)));

  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags ^ $past(flags)) & ~$past(ack_vec | rise_evt)) == '0));

  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec & ~rise_evt) != '0) |=> ((flags & $past(ack_vec & ~rise_evt)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec & rise_evt) != '0) |=> ((flags & $past(ack_vec & rise_evt)) == $past(ack_vec & rise_evt)));

  assert_ack_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_ACK) |-> (rd_data == '0));

  for (genvar k = 0; k < NPWM; k++) begin : g_cap
    localparam int SEL = sense_of(k, NPWM, NSENSE);
    assert_sample_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[k] |=> (samples[k] == $past(sense_s[SEL])));
  end

  assert_sample_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt == '0) |=> $stable(samples));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rise_evt != '0));
endmodule

bind pwm_fault_monitor pwm_fault_monitor_chk #(
  .NFAULT(NFAULT), .NPWM(NPWM), .NSENSE(NSENSE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd_data),
  .irq(irq), .rise_evt(rise_evt), .ack_vec(ack_vec), .flags(flags),
  .sense_s(sense_s), .cap_evt(cap_evt), .samples(samples)
);

// File: tb/pwm_fault_monitor_tb_top.sv
`timescale 1ns/1ps
module pwm_fault_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] fault_pin = '0;
  logic [2:0] sense_pin = '0;
  logic [5:0] pwm_drive = '0, dt_active = '0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  logic [5:0] exp_samp = '0;

  always #2.5 clk = ~clk;

  pwm_fault_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .fault_pin(fault_pin),
    .sense_pin(sense_pin), .pwm_drive(pwm_drive), .dt_active(dt_active),
    .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  // Raise the given pins, let flags latch, drop them, let synchronizers settle
  task automatic pulse_faults(input logic [3:0] p);
    fault_pin = p;
    cyc(3);
    fault_pin = '0;
    cyc(3);
  endtask

  // One dead-time interval on channel k, ending with pwm_drive[k] at level on
  task automatic dead_time(input int k, input logic on);
    dt_active[k] = 1'b1; pwm_drive[k] = 1'b0;
    cyc(2);
    dt_active[k] = 1'b0; pwm_drive[k] = on;
    cyc(1);
    pwm_drive[k] = 1'b0;
    cyc(1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    cyc(3);
    // R1: reset state
    bus_rd(2'd0, d); chk("R1 flags after reset", d, 0);
    bus_rd(2'd2, d); chk("R1 samples after reset", d, 0);
    chk("R1 irq after reset", irq, 0);
    rst_n = 1'b1;
    cyc(2);
    bus_rd(2'd0, d); chk("R1 flags after release", d, 0);

    // R2: latency per channel
    for (int i = 0; i < 4; i++) begin
      fault_pin[i] = 1'b1;
      cyc(2);
      bus_rd(2'd0, d); chk("R2 flag not yet set (sync latency)", d[i], 0);
      cyc(1);
      bus_rd(2'd0, d); chk("R2 flag set two cycles after sampling", d, 1 << i);
      chk("R9 irq with one flag", irq, 1);
      // R2/R3: held high, ack clears, no re-set
      bus_wr(2'd1, 8'(1 << i));
      cyc(4);
      bus_rd(2'd0, d); chk("R2 level held high does not re-set", d, 0);
      chk("R9 irq clear", irq, 0);
      fault_pin[i] = 1'b0;
      cyc(3);
    end

    // R3/R4/R9/R10: sweep of flag patterns and acknowledge patterns
    for (int p = 0; p < 16; p++) begin
      for (int a = 0; a < 16; a++) begin
        bus_wr(2'd1, 8'h0F);
        pulse_faults(4'(p));
        bus_rd(2'd0, d); chk("R3 flags sticky after pins drop", d, p);
        bus_wr(2'd1, {4'hF, 4'(a)});
        bus_rd(2'd0, d); chk("R4 ack clears selected flags", d, p & ~a);
        chk("R9 irq equals OR of flags", irq, ((p & ~a) != 0) ? 1 : 0);
        bus_rd(2'd1, d); chk("R6 ack register reads zero", d, 0);
      end
    end
    bus_wr(2'd1, 8'h0F);

    // R5: edge and acknowledge on the same clock edge
    for (int i = 0; i < 4; i++) begin
      pulse_faults(4'(1 << i));
      fault_pin[i] = 1'b1;
      cyc(2);
      addr = 2'd1; wr_data = 8'(1 << i); wr_en = 1'b1;
      cyc(1);
      wr_en = 1'b0;
      bus_rd(2'd0, d); chk("R5 set wins over same-cycle ack", d, 1 << i);
      fault_pin[i] = 1'b0;
      cyc(3);
      bus_wr(2'd1, 8'h0F);
    end

    // R10: map details
    pulse_faults(4'hF);
    bus_rd(2'd3, d); chk("R10 unmapped address reads zero", d, 0);
    addr = 2'd0; rd_en = 1'b0;
    #1 chk("R10 rd_data zero without rd_en", rd_data, 0);
    bus_rd(2'd0, d); chk("R10 flags in low nibble only", d, 8'h0F);
    bus_wr(2'd1, 8'h0F);

    // R7: each channel, both levels, other sense lines opposite
    for (int v = 1; v >= 0; v--) begin
      for (int k = 0; k < 6; k++) begin
        sense_pin = (v != 0) ? 3'(1 << (k / 2)) : ~3'(1 << (k / 2));
        cyc(4);
        dead_time(k, 1'b1);
        exp_samp[k] = 1'(v);
        bus_rd(2'd2, d); chk("R7 sample captures mapped sense input", d, exp_samp);
      end
    end

    // R8: no capture when output stays off, writes ignored
    for (int k = 0; k < 6; k++) begin
      sense_pin = 3'h7;
      cyc(4);
      dead_time(k, 1'b0);
      bus_rd(2'd2, d); chk("R8 dead-time end with output off ignored", d, exp_samp);
    end
    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd2, d); chk("R8 write to samples ignored", d, exp_samp);
    cyc(5);
    bus_rd(2'd2, d); chk("R8 samples hold", d, exp_samp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule